// File: doc/BRIEF.md
# Phase Realignment Control Sequencer

This block sequences a request to bring a clock generator's outputs back into phase with the reference it tracks. A clear input, active low, asks for the realignment. The request is honoured only if the lock indicator is high when the clear input falls. The clear must then stay low for a minimum time that depends on the rate class of the reference: a short hold for the three fast reference rates, and a long hold for the 8 kHz frame-rate reference. When the clear input returns high after a long enough hold, the block sends a one-cycle relock request to the PLL core. That request restarts the whole locking procedure, and the procedure ends with the outputs phase aligned.

The block also drives the lock indicator that the outside world sees. A fixed delay after the clear input falls, the indicator is forced low. It then stays low for a fixed window while the core relocks. After the window it follows the core's lock status again. All long intervals are counted in ticks of an internal timebase. The tick period (`TICK_DIV` clocks) and every interval (`SHORT_HOLD`, `LONG_HOLD`, `DROP_DELAY`, `LOW_WINDOW`) are parameters, so a simulation can run with shortened intervals. The defaults assume a 100 MHz clock and a 50 µs tick. That gives 250 µs, 10 s, 5 s and 10 s.

The sequencer has four states:

- `ST_IDLE`: monitoring.
- `ST_HOLD`: clear is low and its hold time is being measured.
- `ST_RELOCK`: the single cycle that issues the request.
- `ST_WINDOW`: waiting for the indicator window to end.

It has six transitions:

- **arm**: IDLE→HOLD, when the clear is low and the core is locked.
- **abort**: HOLD→IDLE, when the clear is released too early.
- **accept**: HOLD→RELOCK, when the clear is released after the minimum hold.
- **settle**: RELOCK→WINDOW.
- **late**: RELOCK→IDLE, when the window has already ended.
- **finish**: WINDOW→IDLE, when the window ends.

Top module: `phase_align_seq`

## Requirements
- R1: After reset, `relock_req` is 0 and `lock_ind` equals `core_locked`.
- R2: A fall of `clr_n` while `core_locked` is 0 (indicator low) is ignored: no relock request is issued and `lock_ind` keeps following `core_locked`.
- R3: For `rate_sel` codes 1, 2 and 3 (1.544 MHz, 2.048 MHz, 19.44 MHz), the clear is accepted only if at least `SHORT_HOLD` timebase ticks occur while it is low. A shorter pulse issues no request.
- R4: For `rate_sel` code 0 (8 kHz), the clear is accepted only after `LONG_HOLD` ticks. A shorter hold aborts the sequence, and `lock_ind` then follows `core_locked` again.
- R5: An accepted clear produces exactly one `relock_req` pulse, one clock wide, in the cycle after `clr_n` is sampled high.
- R6: Once `DROP_DELAY` ticks have passed since the accepted fall of `clr_n`, `lock_ind` is 0. This holds even if `clr_n` is still low.
- R7: `lock_ind` stays 0 for exactly `LOW_WINDOW` ticks and then follows `core_locked` again.
- R8: Falls of `clr_n` during a running sequence are ignored and issue no extra request.
- R9: The rate class is captured when `clr_n` falls. Later changes of `rate_sel` do not change the required hold.
- R10: One timebase tick occurs every `TICK_DIV` clocks, counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_n | input | 1 | Realignment clear request, active low |
| core_locked | input | 1 | Lock status from the PLL core |
| rate_sel | input | 2 | Detected reference rate: 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 19.44 MHz |
| relock_req | output | 1 | One-cycle request to the core to restart locking |
| lock_ind | output | 1 | Lock indicator seen outside the block |

## Verification
The clear input is tried with several patterns:

- a pulse while unlocked;
- a fast-rate pulse below the minimum hold, and one well above it;
- an 8 kHz hold that passes the fast minimum but not the slow one;
- an 8 kHz hold that outlasts the drop delay;
- a second pulse inside a running window;
- a rate change in the middle of a hold.

Together these separate a lock gate that is missing, a hold threshold that is wrong or swapped between rate classes, and a rate class that is read live instead of captured. Measuring the length of the indicator's low window, with the clear both released early and held past the drop, exposes errors in the window length and in the tick period.

// File: rtl/pas_pkg.sv
package pas_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RELOCK = 2'd2,
        ST_WINDOW = 2'd3
    } seq_state_t;

    localparam logic [1:0] RATE_FRAME_8K = 2'd0;
endpackage

// File: rtl/pas_tick_gen.sv
module pas_tick_gen #(
    parameter int TICK_DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == DIV_W'(TICK_DIV - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign tick = (div_q == DIV_W'(TICK_DIV - 1));

            // R10: ticks are never back to back when the divider exceeds one
            a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pas_elapsed.sv
module pas_elapsed #(
    parameter int END_TICKS = 300000,
    parameter int CNT_W     = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] elapsed,
    output logic             at_end
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_W'(END_TICKS))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign elapsed = cnt_q;
    assign at_end  = (cnt_q == CNT_W'(END_TICKS));

    // R7: the window counter saturates and never passes the end of the window
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(END_TICKS));

    // R10: the count advances only on a timebase tick
    a_r10_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pas_hold_rule.sv
module pas_hold_rule #(
    parameter int SHORT_HOLD = 5,
    parameter int LONG_HOLD  = 200000,
    parameter int CNT_W      = 19
) (
    input  logic [1:0]       rate_class,
    input  logic [CNT_W-1:0] held_ticks,
    output logic             hold_met
);
    import pas_pkg::*;

    logic [CNT_W-1:0] min_ticks;

    always_comb begin
        if (rate_class == RATE_FRAME_8K) begin
            min_ticks = CNT_W'(LONG_HOLD);
        end else begin
            min_ticks = CNT_W'(SHORT_HOLD);
        end
        hold_met = (held_ticks >= min_ticks);
    end
endmodule

// File: rtl/phase_align_seq.sv
module phase_align_seq #(
    parameter int TICK_DIV   = 5000,
    parameter int SHORT_HOLD = 5,
    parameter int LONG_HOLD  = 200000,
    parameter int DROP_DELAY = 100000,
    parameter int LOW_WINDOW = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_n,
    input  logic       core_locked,
    input  logic [1:0] rate_sel,
    output logic       relock_req,
    output logic       lock_ind
);
    import pas_pkg::*;

    localparam int END_TICKS = DROP_DELAY + LOW_WINDOW;
    localparam int CNT_W     = $clog2(END_TICKS + 1);

    seq_state_t       state_q, state_d;
    logic [1:0]       rate_q;
    logic             tick;
    logic             timer_clear;
    logic [CNT_W-1:0] elapsed;
    logic             at_end;
    logic             hold_met;
    logic             in_window;

    pas_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign timer_clear = (state_q == ST_IDLE);

    pas_elapsed #(.END_TICKS(END_TICKS), .CNT_W(CNT_W)) u_elapsed (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .tick    (tick),
        .elapsed (elapsed),
        .at_end  (at_end)
    );

    pas_hold_rule #(.SHORT_HOLD(SHORT_HOLD), .LONG_HOLD(LONG_HOLD), .CNT_W(CNT_W)) u_rule (
        .rate_class (rate_q),
        .held_ticks (elapsed),
        .hold_met   (hold_met)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clr_n && core_locked) state_d = ST_HOLD;        // arm
            end
            ST_HOLD: begin
                if (clr_n) state_d = hold_met ? ST_RELOCK : ST_IDLE; // accept / abort
            end
            ST_RELOCK: begin
                state_d = at_end ? ST_IDLE : ST_WINDOW;              // late / settle
            end
            ST_WINDOW: begin
                if (at_end) state_d = ST_IDLE;                       // finish
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and captured rate class
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rate_q  <= RATE_FRAME_8K;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_HOLD) rate_q <= rate_sel;
        end
    end

    // Outputs
    always_comb begin
        in_window  = (state_q != ST_IDLE) &&
                     (elapsed >= CNT_W'(DROP_DELAY)) && !at_end;
        relock_req = (state_q == ST_RELOCK);
        lock_ind   = core_locked && !in_window;
    end

    // R5: the request is one cycle wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        relock_req |=> !relock_req);

    // R5: a request follows only a release of the clear at the end of a hold
    a_r5_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relock_req) |-> ($past(clr_n) && $past(state_q == ST_HOLD)));

    // R3 and R4: a request implies the hold rule was met
    a_r3_r4_hold_met: assert property (@(posedge clk) disable iff (!rst_n)
        relock_req |-> hold_met);

    // R2: an unlocked core never starts a sequence
    a_r2_locked_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !core_locked) |=> (state_q == ST_IDLE));

    // R9: the rate class stays put while a sequence runs
    a_r9_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_d != ST_IDLE) |=> $stable(rate_q));

    // R8: a running sequence never re-enters the hold state
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WINDOW) |=> (state_q != ST_HOLD));
endmodule

// File: tb/phase_align_seq_tb_top.sv
module phase_align_seq_tb_top;
    localparam int TD    = 4;
    localparam int SHORT = 5;
    localparam int LONG  = 30;
    localparam int DROP  = 20;
    localparam int LOWW  = 40;
    localparam int ENDT  = DROP + LOWW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       core_locked = 1'b0;
    logic [1:0] rate_sel = 2'd1;
    logic       relock_req;
    logic       lock_ind;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int low_cycles = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // reference model
    int m_state = 0;
    int m_e = 0;
    int m_rate = 0;
    int m_n = 0;

    always #5 clk = ~clk;

    phase_align_seq #(
        .TICK_DIV(TD), .SHORT_HOLD(SHORT), .LONG_HOLD(LONG),
        .DROP_DELAY(DROP), .LOW_WINDOW(LOWW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .core_locked(core_locked),
        .rate_sel(rate_sel), .relock_req(relock_req), .lock_ind(lock_ind)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural model stepped on every clock and compared with the outputs
    always @(posedge clk) begin
        bit tk;
        bit met;
        int ns;
        bit exp_relock;
        bit exp_lock;
        #2;
        if (!rst_n) begin
            m_state = 0; m_e = 0; m_rate = 0; m_n = 0;
        end else begin
            tk = ((m_n % TD) == TD - 1);
            m_n++;
            ns = m_state;
            if (m_state == 0) begin
                if (!clr_n && core_locked) begin
                    ns = 1;
                    m_rate = rate_sel;
                end
            end else if (m_state == 1) begin
                met = (m_e >= ((m_rate == 0) ? LONG : SHORT));
                if (clr_n) ns = met ? 2 : 0;
            end else begin
                ns = (m_e >= ENDT) ? 0 : 3;
            end
            if (m_state == 0) m_e = 0;
            else if (tk && m_e < ENDT) m_e++;
            m_state = ns;

            exp_relock = (m_state == 2);
            exp_lock = core_locked && !(m_state != 0 && m_e >= DROP && m_e < ENDT);
            check({cur_tag, " relock_req"}, relock_req, exp_relock);
            check({cur_tag, " lock_ind"}, lock_ind, exp_lock);
            if (relock_req) pulses++;
            if (!lock_ind) low_cycles++;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_scn(input string tag);
        @(negedge clk);
        cur_tag = tag;
        pulses = 0;
        low_cycles = 0;
    endtask

    task automatic pulse_clear(input int low_len);
        clr_n = 1'b0;
        cycles(low_len);
        clr_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R1: reset state
        check("R1 relock in reset", relock_req, 1'b0);
        check("R1 lock in reset", lock_ind, 1'b0);
        rst_n = 1'b1;
        cycles(2);
        core_locked = 1'b1;
        cycles(2);
        check("R1 lock follows core", lock_ind, 1'b1);

        // R2: clear while unlocked is ignored
        start_scn("R2");
        core_locked = 1'b0;
        cycles(2);
        pulse_clear(40);
        cycles(5);
        core_locked = 1'b1;
        cycles(3);
        check_int("R2 no request", pulses, 0);
        check("R2 lock follows core", lock_ind, 1'b1);

        // R3: too short a pulse at a fast rate
        start_scn("R3");
        rate_sel = 2'd2;
        pulse_clear(8);
        cycles(40);
        check_int("R3 short pulse no request", pulses, 0);

        // R5, R7, R8, R10: accepted at a fast rate, with a stray pulse in the window
        start_scn("R5");
        rate_sel = 2'd3;
        pulse_clear(40);
        cycles(30);
        cur_tag = "R8";
        pulse_clear(40);
        cycles(300);
        check_int("R5 one request", pulses, 1);
        check_int("R8 stray pulse ignored", pulses, 1);
        check_int("R7 R10 window length", low_cycles, LOWW * TD);
        check("R7 lock restored", lock_ind, 1'b1);

        // R4: slow rate hold past fast minimum but below slow minimum
        start_scn("R4");
        rate_sel = 2'd0;
        pulse_clear(88);
        cycles(4);
        check_int("R4 short slow hold no request", pulses, 0);
        check("R4 abort restores lock", lock_ind, 1'b1);
        cycles(20);

        // R4, R6: slow rate long hold, indicator drops while clear still low
        start_scn("R6");
        rate_sel = 2'd0;
        clr_n = 1'b0;
        cycles(100);
        check("R6 lock low during hold", lock_ind, 1'b0);
        cycles(40);
        clr_n = 1'b1;
        cycles(200);
        check_int("R4 long slow hold one request", pulses, 1);
        check_int("R6 window length", low_cycles, LOWW * TD);

        // R9: rate captured at the fall
        start_scn("R9");
        rate_sel = 2'd1;
        clr_n = 1'b0;
        cycles(1);
        rate_sel = 2'd0;
        cycles(39);
        clr_n = 1'b1;
        cycles(300);
        check_int("R9 captured rate accepted", pulses, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule